// File: doc/BRIEF.md
# UART Interrupt Identification and Line Status Core

This block is the interrupt arbitration and line-error bookkeeping of a 16550-style UART register file. It watches receive events (one strobe per received byte with framing, parity and break flags, plus a separate overrun pulse), the receive-data-ready level and transmit-holding-register empty events. From these it keeps sticky error bits and a pending transmit-empty flag. It then presents an identification code for the highest-priority enabled source and an interrupt request line.

A mode input picks between two clearing rules. In the standard rule, a status read wipes the error bits. A pending transmit-empty indication survives identification reads that report a higher source. In the alternate rule, status reads leave the errors alone and the next clean received byte clears them. Every identification read also drops the pending transmit-empty flag. Software written for the alternate rule must refill the transmitter without waiting for that flag to reappear.

Top module: `uarti_core`

## Requirements
- R1: After reset the identification code is 4'b0001, the error bits are all zero and the interrupt request is low.
- R2: Priority of reported sources is line errors (code 4'b0110), then receive data ready (code 4'b0100), then transmit-empty (code 4'b0010); with none enabled and pending the code is 4'b0001.
- R3: In standard mode (variant_mode=0), an identification read while a higher source is reported leaves a pending transmit-empty indication, which is reported once the higher sources are gone.
- R4: In standard mode, an identification read that reports transmit-empty (4'b0010) clears it.
- R5: In either mode, a write strobe to the transmit holding register clears a pending transmit-empty indication.
- R6: In variant mode (variant_mode=1), any identification read clears a pending transmit-empty indication, whatever code it reports.
- R7: In variant mode, a line status read changes neither the error bits nor the line-error interrupt.
- R8: In variant mode, error bits stay set through further bad bytes and all clear on the next received byte that has no framing, parity or break flag.
- R9: Error bits on lsr_err[4:1] are overrun at bit 1, parity at bit 2, framing at bit 3, break at bit 4; each is sticky, and in standard mode a line status read clears them all.
- R10: Enables irq_en[0] receive data, irq_en[1] transmit-empty, irq_en[2] line errors mask their sources; irq is high exactly when the code is not 4'b0001.
- R11: A transmit-empty indication is raised by a transmit-empty event, and by irq_en[1] rising while the holding register is empty (empty from reset until a write strobe).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_mode | input | 1 | 0 standard clearing rule, 1 alternate rule |
| irq_en | input | 3 | Source enables: bit0 receive, bit1 transmit-empty, bit2 line errors |
| rx_byte_vld | input | 1 | One-cycle strobe per received byte |
| rx_par_err | input | 1 | Parity flag of the strobed byte |
| rx_frm_err | input | 1 | Framing flag of the strobed byte |
| rx_brk | input | 1 | Break flag of the strobed byte |
| rx_ovr | input | 1 | One-cycle overrun event |
| rx_ready | input | 1 | Receive data available level |
| thr_empty_evt | input | 1 | One-cycle event: holding register became empty |
| thr_wr | input | 1 | Write strobe of the transmit holding register |
| iir_rd | input | 1 | Read strobe of the identification register |
| lsr_rd | input | 1 | Read strobe of the line status register |
| iir_id | output | 4 | Identification code of the reported source |
| lsr_err | output | 4 | Error bits, indexed 4:1 |
| irq | output | 1 | Interrupt request |

## Verification
Both error and transmit-empty state are held in registers that drive the identification code directly. A wrong bit shows at iir_id, lsr_err and irq in the cycle after the strobe or event that set it. A transmit-empty flag that is wrongly kept or lost is hidden while a higher source is reported. It only shows once those sources are gone, so the tests remove the higher sources one at a time and read the code after each step. Mode mix-ups show when a status or identification read leaves, or fails to leave, its effect on the next cycle's code.

// File: rtl/uarti_pkg.sv
package uarti_pkg;
    localparam int ERR_W = 4;
    localparam int EN_W  = 3;
    localparam int EN_RX = 0;
    localparam int EN_TH = 1;
    localparam int EN_LS = 2;

    typedef enum logic [3:0] {
        ID_NONE = 4'b0001,
        ID_LINE = 4'b0110,
        ID_RXD  = 4'b0100,
        ID_THRE = 4'b0010
    } iir_code_e;

    typedef struct packed {
        logic [ERR_W-1:0] err;   // {break, framing, parity, overrun}
    } err_state_t;

    typedef struct packed {
        logic pend;
        logic empty;
        logic en_prev;
    } thre_state_t;
endpackage

// File: rtl/uarti_err_track.sv
module uarti_err_track
    import uarti_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             variant_mode,
    input  logic             byte_vld,
    input  logic             par_err,
    input  logic             frm_err,
    input  logic             brk,
    input  logic             ovr,
    input  logic             lsr_rd,
    output logic [ERR_W-1:0] err
);
    err_state_t st_d, st_q;
    logic [ERR_W-1:0] new_err;
    logic             good_byte;
    logic             clear_now;

    always_comb begin
        st_d      = st_q;
        new_err   = {byte_vld & brk, byte_vld & frm_err, byte_vld & par_err, ovr};
        good_byte = byte_vld & ~(par_err | frm_err | brk);
        clear_now = variant_mode ? good_byte : lsr_rd;
        st_d.err  = (clear_now ? '0 : st_q.err) | new_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err = st_q.err;
endmodule

// File: rtl/uarti_thre_track.sv
module uarti_thre_track
    import uarti_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic variant_mode,
    input  logic en_thre,
    input  logic empty_evt,
    input  logic thr_wr,
    input  logic iir_rd,
    input  logic iir_is_thre,
    output logic pend
);
    thre_state_t st_d, st_q;
    logic rise_en;
    logic rd_clear;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en_thre;
        rise_en      = en_thre & ~st_q.en_prev & st_q.empty;
        rd_clear     = iir_rd & (variant_mode | iir_is_thre);
        if (thr_wr)    st_d.empty = 1'b0;
        if (empty_evt) st_d.empty = 1'b1;
        if (thr_wr || rd_clear) st_d.pend = 1'b0;
        if (empty_evt || rise_en) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend    <= 1'b0;
            st_q.empty   <= 1'b1;
            st_q.en_prev <= en_thre;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/uarti_prio.sv
module uarti_prio
    import uarti_pkg::*;
(
    input  logic            line_pend,
    input  logic            rx_pend,
    input  logic            thre_pend,
    input  logic [EN_W-1:0] en,
    output iir_code_e       code,
    output logic            req
);
    always_comb begin
        if (line_pend && en[EN_LS])     code = ID_LINE;
        else if (rx_pend && en[EN_RX])  code = ID_RXD;
        else if (thre_pend && en[EN_TH]) code = ID_THRE;
        else                            code = ID_NONE;
        req = (code != ID_NONE);
    end
endmodule

// File: rtl/uarti_core.sv
module uarti_core
    import uarti_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            variant_mode,
    input  logic [EN_W-1:0] irq_en,
    input  logic            rx_byte_vld,
    input  logic            rx_par_err,
    input  logic            rx_frm_err,
    input  logic            rx_brk,
    input  logic            rx_ovr,
    input  logic            rx_ready,
    input  logic            thr_empty_evt,
    input  logic            thr_wr,
    input  logic            iir_rd,
    input  logic            lsr_rd,
    output logic [3:0]      iir_id,
    output logic [ERR_W:1]  lsr_err,
    output logic            irq
);
    logic [ERR_W-1:0] err;
    logic             thre_pend;
    iir_code_e        code;

    uarti_err_track err_i (
        .clk(clk), .rst_n(rst_n), .variant_mode(variant_mode),
        .byte_vld(rx_byte_vld), .par_err(rx_par_err), .frm_err(rx_frm_err),
        .brk(rx_brk), .ovr(rx_ovr), .lsr_rd(lsr_rd), .err(err)
    );

    uarti_thre_track thre_i (
        .clk(clk), .rst_n(rst_n), .variant_mode(variant_mode),
        .en_thre(irq_en[EN_TH]), .empty_evt(thr_empty_evt), .thr_wr(thr_wr),
        .iir_rd(iir_rd), .iir_is_thre(code == ID_THRE), .pend(thre_pend)
    );

    uarti_prio prio_i (
        .line_pend(|err), .rx_pend(rx_ready), .thre_pend(thre_pend),
        .en(irq_en), .code(code), .req(irq)
    );

    assign iir_id  = code;
    assign lsr_err = err;
endmodule

// File: rtl/uarti_core_chk.sv
module uarti_core_chk
    import uarti_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            variant_mode,
    input logic [EN_W-1:0] irq_en,
    input logic            rx_byte_vld,
    input logic            rx_par_err,
    input logic            rx_frm_err,
    input logic            rx_brk,
    input logic            rx_ovr,
    input logic            thr_empty_evt,
    input logic            thr_wr,
    input logic            iir_rd,
    input logic            lsr_rd,
    input logic [3:0]      iir_id,
    input logic [ERR_W:1]  lsr_err,
    input logic            irq
);
    assert_irq_matches_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_id != 4'b0001));

    assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_err != '0 && irq_en[EN_LS]) |-> iir_id == 4'b0110);

    assert_std_lsr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!variant_mode && lsr_rd && !rx_byte_vld && !rx_ovr) |=> lsr_err == '0);

    assert_var_lsr_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (variant_mode && lsr_rd && !rx_byte_vld && !rx_ovr) |=> $stable(lsr_err));

    assert_var_good_byte_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (variant_mode && rx_byte_vld && !rx_par_err && !rx_frm_err && !rx_brk && !rx_ovr)
        |=> lsr_err == '0);

    assert_wr_drops_thre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thr_empty_evt && irq_en[EN_TH] && $past(irq_en[EN_TH]))
        |=> iir_id != 4'b0010);

    assert_var_read_drops_thre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (variant_mode && iir_rd && !thr_empty_evt && irq_en[EN_TH] && $past(irq_en[EN_TH]))
        |=> iir_id != 4'b0010);
endmodule

bind uarti_core uarti_core_chk chk_i (
    .clk(clk), .rst_n(rst_n), .variant_mode(variant_mode), .irq_en(irq_en),
    .rx_byte_vld(rx_byte_vld), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .rx_brk(rx_brk), .rx_ovr(rx_ovr), .thr_empty_evt(thr_empty_evt),
    .thr_wr(thr_wr), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
    .iir_id(iir_id), .lsr_err(lsr_err), .irq(irq)
);

// File: tb/uarti_core_tb_top.sv
module uarti_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       variant_mode = 1'b0;
    logic [2:0] irq_en = 3'b000;
    logic       rx_byte_vld = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0, rx_ovr = 0;
    logic       rx_ready = 0, thr_empty_evt = 0, thr_wr = 0, iir_rd = 0, lsr_rd = 0;
    logic [3:0] iir_id;
    logic [4:1] lsr_err;
    logic       irq;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 0;

    always #4 clk = ~clk;   // 125 MHz

    uarti_core dut_i (
        .clk(clk), .rst_n(rst_n), .variant_mode(variant_mode), .irq_en(irq_en),
        .rx_byte_vld(rx_byte_vld), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .rx_brk(rx_brk), .rx_ovr(rx_ovr), .rx_ready(rx_ready),
        .thr_empty_evt(thr_empty_evt), .thr_wr(thr_wr), .iir_rd(iir_rd),
        .lsr_rd(lsr_rd), .iir_id(iir_id), .lsr_err(lsr_err), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // advance one cycle; strobes drop afterwards
    task automatic tick();
        @(negedge clk);
        rx_byte_vld = 0; rx_par_err = 0; rx_frm_err = 0; rx_brk = 0; rx_ovr = 0;
        thr_empty_evt = 0; thr_wr = 0; iir_rd = 0; lsr_rd = 0;
    endtask

    task automatic rx_byte(input logic p, input logic f, input logic b);
        rx_byte_vld = 1; rx_par_err = p; rx_frm_err = f; rx_brk = b;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 code", {4'b0, iir_id}, 8'h01);
        chk("R1 err",  {4'b0, lsr_err}, 8'h00);
        chk("R1 irq",  {7'b0, irq}, 8'h00);
    endtask

    task automatic t_std_priority();
        variant_mode = 0;
        irq_en = 3'b111; tick();
        chk("R11 enable rise while empty", {4'b0, iir_id}, 8'h02);
        rx_ready = 1; tick();
        chk("R2 rx over thre", {4'b0, iir_id}, 8'h04);
        rx_byte(1, 0, 0);
        chk("R9 parity bit2", {4'b0, lsr_err}, 8'h02);
        chk("R2 line first", {4'b0, iir_id}, 8'h06);
        iir_rd = 1; tick();
        lsr_rd = 1; tick();
        chk("R9 std status read clears", {4'b0, lsr_err}, 8'h00);
        chk("R2 rx after line", {4'b0, iir_id}, 8'h04);
        rx_ready = 0; tick();
        chk("R3 thre survived read", {4'b0, iir_id}, 8'h02);
        chk("R10 irq with thre", {7'b0, irq}, 8'h01);
        iir_rd = 1; tick();
        chk("R4 read of thre clears", {4'b0, iir_id}, 8'h01);
        chk("R10 irq idle", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_write_clears();
        thr_empty_evt = 1; tick();
        chk("R11 empty event raises", {4'b0, iir_id}, 8'h02);
        thr_wr = 1; tick();
        chk("R5 write clears thre", {4'b0, iir_id}, 8'h01);
        rx_ovr = 1; tick();
        chk("R9 overrun bit1", {4'b0, lsr_err}, 8'h01);
        lsr_rd = 1; tick();
        chk("R9 cleared again", {4'b0, lsr_err}, 8'h00);
    endtask

    task automatic t_var_thre();
        variant_mode = 1;
        thr_empty_evt = 1; tick();
        rx_ready = 1; tick();
        chk("R2 rx reported", {4'b0, iir_id}, 8'h04);
        iir_rd = 1; tick();
        rx_ready = 0; tick();
        chk("R6 thre dropped by any read", {4'b0, iir_id}, 8'h01);
    endtask

    task automatic t_var_errors();
        rx_byte(0, 1, 0);
        chk("R9 framing bit3", {4'b0, lsr_err}, 8'h04);
        lsr_rd = 1; tick();
        chk("R7 status read keeps err", {4'b0, lsr_err}, 8'h04);
        chk("R7 status read keeps int", {4'b0, iir_id}, 8'h06);
        rx_byte(0, 0, 1);
        chk("R8 bad byte accumulates", {4'b0, lsr_err}, 8'h0C);
        rx_ovr = 1; tick();
        chk("R8 overrun adds", {4'b0, lsr_err}, 8'h0D);
        rx_byte(0, 0, 0);
        chk("R8 good byte clears", {4'b0, lsr_err}, 8'h00);
        chk("R8 line int gone", {4'b0, iir_id}, 8'h01);
    endtask

    task automatic t_mask();
        variant_mode = 0;
        irq_en = 3'b000;
        rx_byte(0, 0, 1);
        chk("R9 break bit4", {4'b0, lsr_err}, 8'h08);
        chk("R10 masked code", {4'b0, iir_id}, 8'h01);
        chk("R10 masked irq", {7'b0, irq}, 8'h00);
        irq_en = 3'b100; tick();
        chk("R10 line enabled irq", {7'b0, irq}, 8'h01);
        chk("R10 line enabled code", {4'b0, iir_id}, 8'h06);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_std_priority();
        t_write_clears();
        t_var_thre();
        t_var_errors();
        t_mask();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule